// File: doc/BRIEF.md
# Sector Lock Command Sequencer

This block watches the write bus of a sectored memory for a short command sequence that changes the protection of individual sectors. It holds one lock bit for every sector and reports, for each sector, whether program or erase writes are allowed. The program and erase logic can ask about any address through a combinational query port. It gets the answer in the same cycle and can refuse requests aimed at protected sectors.

The sequence starts with two prefix writes of data 60h to any address. After that the sequencer is armed. Each further 60h write names a sector in its upper address bits and uses one address bit to choose between lock and unlock. The armed state lasts until an exit write of F0h arrives, or until a write carries data that is not part of the sequence. An active-low write-protect input forces the first and the last sector to read as locked. The stored bits are left unchanged.

Top module: `sector_lock_seq`

## Requirements
- R1: After reset every sector reads as locked (`lock_mask` all ones, `qry_wr_ok` low for every address) and `seq_armed` is low.
- R2: Two consecutive accepted writes (`wr_en` high) of data 60h, at any addresses, arm the sequencer. `seq_armed` rises in the cycle after the second write's clock edge. A cycle with `wr_en` low does not advance the sequence.
- R3: An armed write of 60h selects sector `wr_addr[SECT_SHIFT +: log2(NUM_SECT)]`. With `wr_addr[6]` at 0 it locks that sector, and with 1 it unlocks it. The new value appears on `lock_mask` and the query port in the cycle after the write's clock edge. No other sector changes.
- R4: While armed, any number of 60h writes can follow one after another, each updating one sector, with no repeat of the prefix.
- R5: A write of F0h, at any address and in any state, returns the sequencer to idle without changing any lock bit.
- R6: A write whose data is neither 60h nor F0h returns the sequencer to idle and changes no lock bit. A 60h write during the prefix only advances the prefix and changes no lock bit.
- R7: While `wp_n` is low, sectors 0 and NUM_SECT-1 read as locked on `lock_mask` and the query port. Their stored state shows again once `wp_n` returns high.
- R8: `qry_wr_ok` is high in the same cycle exactly when the sector holding `qry_addr` reads as unlocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, sets every sector locked |
| wr_en | input | 1 | Write cycle strobe |
| wr_addr | input | ADDR_W | Write address; sector index and lock/unlock select bit |
| wr_data | input | 8 | Write data, the command code |
| wp_n | input | 1 | Active-low write protect for the two outermost sectors |
| qry_addr | input | ADDR_W | Address whose sector is queried |
| qry_wr_ok | output | 1 | Queried sector may be programmed or erased |
| lock_mask | output | NUM_SECT | Effective lock state per sector, 1 = locked |
| seq_armed | output | 1 | Prefix complete, sector commands accepted |

## Verification
A write sampled at a rising edge changes `seq_armed` and `lock_mask` right after that edge, one register stage. The bench therefore drives each write at a falling edge and compares against its behavioural model at the next falling edge. The query port and the write-protect masking have no register in the path. The bench checks them after a short settling delay in the same low phase, sweeping `qry_addr` over every sector while the other inputs are held.

// File: rtl/sector_lock_seq.sv
module sector_lock_seq #(
  parameter int ADDR_W     = 16,
  parameter int NUM_SECT   = 16,
  parameter int SECT_SHIFT = 12,
  parameter int SEL_BIT    = 6,
  parameter logic [7:0] CMD_LOCK = 8'h60,
  parameter logic [7:0] CMD_EXIT = 8'hF0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [7:0]          wr_data,
  input  logic                wp_n,
  input  logic [ADDR_W-1:0]   qry_addr,
  output logic                qry_wr_ok,
  output logic [NUM_SECT-1:0] lock_mask,
  output logic                seq_armed
);
  localparam int SECT_W = $clog2(NUM_SECT);
  localparam logic [NUM_SECT-1:0] BOOT_MASK = {1'b1, {(NUM_SECT-2){1'b0}}, 1'b1};

  typedef enum logic [1:0] {S_IDLE, S_PRE, S_ARM} st_t;
  st_t st_q, st_d;
  logic [NUM_SECT-1:0] lock_q;

  wire [SECT_W-1:0] wr_sect  = wr_addr[SECT_SHIFT +: SECT_W];
  wire [SECT_W-1:0] qry_sect = qry_addr[SECT_SHIFT +: SECT_W];
  wire              is_lock  = wr_en && (wr_data == CMD_LOCK);

  always_comb begin
    st_d = st_q;
    if (wr_en) begin
      if (wr_data == CMD_LOCK)
        st_d = (st_q == S_IDLE) ? S_PRE : S_ARM;
      else
        st_d = S_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      lock_q <= '1;
    end else begin
      st_q <= st_d;
      if (is_lock && st_q == S_ARM)
        lock_q[wr_sect] <= ~wr_addr[SEL_BIT];
    end
  end

  assign lock_mask = lock_q | (wp_n ? '0 : BOOT_MASK);
  assign qry_wr_ok = ~lock_mask[qry_sect];
  assign seq_armed = (st_q == S_ARM);

  AST_LOCK_ONLY_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q != $past(lock_q)) |-> $past(seq_armed && wr_en && wr_data == CMD_LOCK)); // R6
  AST_ONE_SECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(lock_q ^ $past(lock_q)) <= 1); // R3
  AST_EXIT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data == CMD_EXIT) |=> !seq_armed); // R5
  AST_WP_BOOT: assert property (@(posedge clk) disable iff (!rst_n)
    !wp_n |-> (lock_mask[0] && lock_mask[NUM_SECT-1])); // R7
  AST_ARM_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seq_armed) |-> $past(wr_en && wr_data == CMD_LOCK)); // R2
  AST_QRY_WP: assert property (@(posedge clk) disable iff (!rst_n)
    (!wp_n && qry_sect == '0) |-> !qry_wr_ok); // R8
endmodule

// File: tb/sector_lock_seq_tb.sv
module sector_lock_seq_tb_top;
  localparam int NS = 16;
  logic clk = 0, rst_n = 0, wr_en = 0, wp_n = 1;
  logic [15:0] wr_addr = 0, qry_addr = 0;
  logic [7:0]  wr_data = 0;
  logic        qry_wr_ok, seq_armed;
  logic [NS-1:0] lock_mask;
  int n_chk = 0, n_fail = 0;
  int m_st = 0;
  bit m_lock [NS];

  always #5 clk = ~clk;

  sector_lock_seq dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wp_n(wp_n), .qry_addr(qry_addr), .qry_wr_ok(qry_wr_ok),
    .lock_mask(lock_mask), .seq_armed(seq_armed));

  function automatic bit eff(int s);
    return m_lock[s] || (!wp_n && (s == 0 || s == NS-1));
  endfunction

  task automatic chk(string tag);
    logic [NS-1:0] exp_m;
    for (int s = 0; s < NS; s++) exp_m[s] = eff(s);
    n_chk++;
    if (lock_mask !== exp_m) begin
      n_fail++; $display("FAIL %s lock_mask act=%h exp=%h", tag, lock_mask, exp_m);
    end
    n_chk++;
    if (seq_armed !== (m_st == 2)) begin
      n_fail++; $display("FAIL %s seq_armed act=%b exp=%b", tag, seq_armed, m_st == 2);
    end
    for (int s = 0; s < NS; s++) begin
      qry_addr = 16'(s << 12) | 16'h0155;
      #1;
      n_chk++;
      if (qry_wr_ok !== !eff(s)) begin
        n_fail++; $display("FAIL %s R8 qry sector %0d act=%b exp=%b", tag, s, qry_wr_ok, !eff(s));
      end
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d, input logic en, input string tag);
    wr_addr = a; wr_data = d; wr_en = en;
    @(posedge clk);
    if (en) begin
      if (d == 8'h60) begin
        if (m_st == 2) m_lock[(a >> 12) & 15] = !a[6];
        else m_st = m_st + 1;
      end else m_st = 0;
    end
    @(negedge clk);
    wr_en = 0;
    chk(tag);
  endtask

  function automatic logic [15:0] sa(int s, bit unl);
    return 16'(s << 12) | (unl ? 16'h0040 : 16'h0000) | 16'h0021;
  endfunction

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int s = 0; s < NS; s++) m_lock[s] = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset");
    wr(16'h1234, 8'h60, 1, "R2 prefix1");
    wr(16'h0000, 8'h60, 0, "R2 idle cycle");
    wr(16'hBEEF, 8'h60, 1, "R2 prefix2");
    wr(sa(3, 1), 8'h60, 1, "R3 unlock s3");
    wr(sa(5, 1), 8'h60, 1, "R4 unlock s5");
    wr(sa(9, 1), 8'h60, 1, "R4 unlock s9");
    wr(sa(3, 0), 8'h60, 1, "R3 relock s3");
    wr(16'h7777, 8'hF0, 1, "R5 exit");
    wr(sa(5, 0), 8'h60, 1, "R6 prefix no change");
    wr(sa(6, 1), 8'h55, 1, "R6 abort");
    wr(sa(6, 1), 8'h60, 1, "R6 prefix after abort");
    wr(sa(6, 1), 8'hF0, 1, "R5 exit during prefix");
    wr(16'h0, 8'h60, 1, "R2 prefix1");
    wr(16'h0, 8'h60, 1, "R2 prefix2");
    wr(sa(0, 1), 8'h60, 1, "R3 unlock s0");
    wr(sa(NS-1, 1), 8'h60, 1, "R4 unlock last");
    wr(sa(2, 1), 8'h33, 1, "R6 abort armed");
    wr(sa(2, 1), 8'h60, 1, "R6 60h after abort");
    wr(16'h0, 8'hF0, 1, "R5 exit");
    wp_n = 0; #1;
    chk("R7 wp low");
    wr(16'h0, 8'h60, 1, "R7 prefix under wp");
    wr(16'h0, 8'h60, 1, "R7 prefix2 under wp");
    wr(sa(NS-1, 1), 8'h60, 1, "R7 unlock last under wp");
    wr(sa(0, 0), 8'h60, 1, "R7 lock s0 under wp");
    wp_n = 1; #1;
    chk("R7 wp released");
    wr(16'h0, 8'hF0, 1, "R5 final exit");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule